// File: doc/BRIEF.md
# Audio Converter Control Register Bank with Staged Commit

This block holds the control settings of an audio converter and drives them as live signals into the converter: a mute bit and an inversion bit per channel, and an 8-bit volume byte per DAC channel and per ADC channel. Software reaches it through a plain byte-wide port. A write is taken on any clock edge where `wr_en` is high. Read data is combinational from `addr`. The bank also stores the master-clock ratio code and the auxiliary serial format bit, and exports them.

The mute, inversion and volume registers are double-buffered. Each one has a pending copy, which is what software writes and reads, and a live copy, which drives the outputs. While the freeze bit is clear, the two copies move together. While freeze is set, only the pending copies change. When freeze is cleared, every staged setting reaches the outputs on a single clock edge, so a multi-register change such as a balance adjustment lands without audible intermediate states.

The register map, with the default of four DAC channels and two ADC channels:

| Address | Contents |
|---|---|
| 0x00 | clock ratio code in bits 3:1 |
| 0x01 | freeze in bit 7, auxiliary format in bit 6 |
| 0x02 | mute |
| 0x03 | inversion |
| 0x04 to 0x07 | DAC volume for channels 0 to 3 |
| 0x08 to 0x09 | ADC volume for channels 0 and 1 |

In the mute and inversion registers, bit i is DAC channel i, and bit DAC_CH+j is ADC channel j.

Top module: `ctl_regfile`

## Requirements
- R1: While `rst_n` is low and immediately after it rises, every output is 0 and every address reads back 0x00.
- R2: A write to 0x01 sets `freeze_o` from bit 7 and `aux_i2s_o` from bit 6 on the next edge (0 = left-justified, 1 = I2S). Reads of 0x01 return those two bits in the same positions.
- R3: A write to 0x00 stores bits 3:1 as the ratio code, and reads return that code in bits 3:1. `ratio_sel_o` gives 0 to 3 for codes 000 to 011 and gives 4 for any code with bit 2 set.
- R4: Reserved bits ignore written data and read as 0. These are bits 7:4 and 0 of 0x00, bits 5:0 of 0x01, and bits 7:6 of 0x02 and 0x03.
- R5: With freeze clear, a write to a mute, inversion or volume register appears on its live output on the next clock edge.
- R6: While freeze stays set, the live mute, inversion and volume outputs do not change, even when those registers are written.
- R7: A read of a mute, inversion or volume register returns the most recently written value, even when it differs from the live output.
- R8: On the edge where `freeze_o` falls, every staged value appears on the live outputs together, and each live output then equals its register's read-back value.
- R9: A write to an address at or above 0x0A changes no output and no stored value. A read of such an address returns 0x00.
- R10: Setting freeze, and rewriting 0x01 with freeze still set (for example to change the format bit), leaves the live outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | ADDR_W (5) | Register address for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| mute_o | output | DAC_CH+ADC_CH (6) | Live per-channel mute |
| invert_o | output | DAC_CH+ADC_CH (6) | Live per-channel polarity inversion |
| dac_vol_o | output | 8*DAC_CH (32) | Live DAC volumes, channel i at bits 8i+7:8i |
| adc_vol_o | output | 8*ADC_CH (16) | Live ADC volumes, channel j at bits 8j+7:8j |
| freeze_o | output | 1 | Freeze bit currently in force |
| aux_i2s_o | output | 1 | Auxiliary format: 0 left-justified, 1 I2S |
| ratio_sel_o | output | 3 | Decoded clock ratio index 0 to 4 |

## Verification
The assertions assume at most one write per cycle, through the single port. This means a write that clears freeze never coincides with a staged-register write, and entering freeze never carries a new volume. The commit check also assumes that a read of the mute register follows some freeze releases. The stimulus respects all of this: it drives `addr`, `wr_en` and `wr_data` only on falling edges, issues one operation per cycle, and reads back register 0x02 right after each release.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int BYTE_W     = 8;
    localparam int RATIO_ADDR = 0;
    localparam int MISC_ADDR  = 1;
    localparam int STG_BASE   = 2;
    localparam int FRZ_BIT    = 7;
    localparam int FMT_BIT    = 6;

    typedef struct packed {
        logic       freeze;
        logic       aux_i2s;
        logic [2:0] ratio;
    } cfg_t;

    function automatic logic [2:0] ratio_decode(input logic [2:0] code);
        logic [2:0] sel;
        if (code[2]) sel = 3'd4;
        else         sel = {1'b0, code[1:0]};
        return sel;
    endfunction

endpackage

// File: rtl/ctl_addr_dec.sv
module ctl_addr_dec
    import ctl_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int NSTG   = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_ratio,
    output logic              wr_misc,
    output logic [NSTG-1:0]   wr_stg
);

    always_comb begin
        wr_ratio = wr_en && (addr == ADDR_W'(RATIO_ADDR));
        wr_misc  = wr_en && (addr == ADDR_W'(MISC_ADDR));
    end

    for (genvar k = 0; k < NSTG; k++) begin : g_stg_dec
        assign wr_stg[k] = wr_en && (addr == ADDR_W'(STG_BASE + k));
    end

endmodule

// File: rtl/ctl_stage_reg.sv
module ctl_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         hold,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] live_o
);

    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] live;
    } stg_t;

    stg_t st_q, st_d;

    // hold is the freeze value in force after this edge, so a release
    // commits on the same edge that the freeze bit clears.
    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.pend = wr_data;
        if (!hold) st_d.live = st_d.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign live_o = st_q.live;

endmodule

// File: rtl/ctl_read_mux.sv
module ctl_read_mux
    import ctl_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int NSTG   = 8
) (
    input  logic [ADDR_W-1:0]      addr,
    input  cfg_t                   cfg,
    input  logic [NSTG*BYTE_W-1:0] stg_rd,
    output logic [BYTE_W-1:0]      rd_data
);

    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(RATIO_ADDR)) begin
            rd_data[3:1] = cfg.ratio;
        end else if (addr == ADDR_W'(MISC_ADDR)) begin
            rd_data[FRZ_BIT] = cfg.freeze;
            rd_data[FMT_BIT] = cfg.aux_i2s;
        end else begin
            for (int k = 0; k < NSTG; k++) begin
                if (addr == ADDR_W'(STG_BASE + k))
                    rd_data = stg_rd[k*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
    import ctl_pkg::*;
#(
    parameter int DAC_CH = 4,
    parameter int ADC_CH = 2,
    parameter int ADDR_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [7:0]               wr_data,
    output logic [7:0]               rd_data,
    output logic [DAC_CH+ADC_CH-1:0] mute_o,
    output logic [DAC_CH+ADC_CH-1:0] invert_o,
    output logic [8*DAC_CH-1:0]      dac_vol_o,
    output logic [8*ADC_CH-1:0]      adc_vol_o,
    output logic                     freeze_o,
    output logic                     aux_i2s_o,
    output logic [2:0]               ratio_sel_o
);

    localparam int CH_TOT = DAC_CH + ADC_CH;
    localparam int NSTG   = 2 + CH_TOT;
    localparam int DAC_LO = 2;
    localparam int ADC_LO = 2 + DAC_CH;

    logic                   wr_ratio, wr_misc;
    logic [NSTG-1:0]        wr_stg;
    logic [NSTG*BYTE_W-1:0] stg_rd;
    cfg_t                   cfg_q, cfg_d;

    ctl_addr_dec #(.ADDR_W(ADDR_W), .NSTG(NSTG)) u_dec (
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_ratio (wr_ratio),
        .wr_misc  (wr_misc),
        .wr_stg   (wr_stg)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ratio) cfg_d.ratio = wr_data[3:1];
        if (wr_misc) begin
            cfg_d.freeze  = wr_data[FRZ_BIT];
            cfg_d.aux_i2s = wr_data[FMT_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    for (genvar k = 0; k < NSTG; k++) begin : g_stg
        localparam int W = (k < DAC_LO) ? CH_TOT : BYTE_W;
        logic [W-1:0] pend_w, live_w;

        ctl_stage_reg #(.W(W)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_stg[k]),
            .wr_data (wr_data[W-1:0]),
            .hold    (cfg_d.freeze),
            .pend_o  (pend_w),
            .live_o  (live_w)
        );

        assign stg_rd[k*BYTE_W +: BYTE_W] = BYTE_W'(pend_w);

        if (k == 0) begin : g_mute
            assign mute_o = live_w;
        end else if (k == 1) begin : g_inv
            assign invert_o = live_w;
        end else if (k < ADC_LO) begin : g_dac
            assign dac_vol_o[(k-DAC_LO)*BYTE_W +: BYTE_W] = live_w;
        end else begin : g_adc
            assign adc_vol_o[(k-ADC_LO)*BYTE_W +: BYTE_W] = live_w;
        end
    end

    ctl_read_mux #(.ADDR_W(ADDR_W), .NSTG(NSTG)) u_rd (
        .addr    (addr),
        .cfg     (cfg_q),
        .stg_rd  (stg_rd),
        .rd_data (rd_data)
    );

    assign freeze_o    = cfg_q.freeze;
    assign aux_i2s_o   = cfg_q.aux_i2s;
    assign ratio_sel_o = ratio_decode(cfg_q.ratio);

endmodule

// File: rtl/ctl_regfile_chk.sv
module ctl_regfile_chk #(
    parameter int DAC_CH = 4,
    parameter int ADC_CH = 2,
    parameter int ADDR_W = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        addr,
    input logic [7:0]               wr_data,
    input logic [7:0]               rd_data,
    input logic [DAC_CH+ADC_CH-1:0] mute_o,
    input logic [DAC_CH+ADC_CH-1:0] invert_o,
    input logic [8*DAC_CH-1:0]      dac_vol_o,
    input logic [8*ADC_CH-1:0]      adc_vol_o,
    input logic                     freeze_o,
    input logic                     aux_i2s_o,
    input logic [2:0]               ratio_sel_o
);

    localparam int CH_TOT   = DAC_CH + ADC_CH;
    localparam int MUTE_A   = 2;
    localparam int MAP_END  = 4 + CH_TOT;

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |-> (mute_o == '0 && invert_o == '0 && dac_vol_o == '0 &&
                    adc_vol_o == '0 && !freeze_o && !aux_i2s_o && ratio_sel_o == 3'd0));

    assert_misc_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(1)) |=>
            (freeze_o == $past(wr_data[7]) && aux_i2s_o == $past(wr_data[6])));

    assert_ratio_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_sel_o <= 3'd4);

    assert_ratio_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0)) |=>
            (ratio_sel_o == ($past(wr_data[3]) ? 3'd4 : {1'b0, $past(wr_data[2:1])})));

    assert_rsv_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr == ADDR_W'(0)) |-> (rd_data[7:4] == 4'd0 && !rd_data[0])) and
        ((addr == ADDR_W'(1)) |-> (rd_data[5:0] == 6'd0)));

    assert_live_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(MUTE_A) && !freeze_o) |=>
            (mute_o == $past(wr_data[CH_TOT-1:0])));

    assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_o && $past(freeze_o)) |->
            ($stable(mute_o) && $stable(invert_o) && $stable(dac_vol_o) && $stable(adc_vol_o)));

    assert_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(freeze_o) && !wr_en && addr == ADDR_W'(MUTE_A)) |->
            (rd_data == 8'(mute_o)));

    assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= ADDR_W'(MAP_END)) |-> (rd_data == 8'h00));

    assert_freeze_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freeze_o) |->
            ($stable(mute_o) && $stable(invert_o) && $stable(dac_vol_o) && $stable(adc_vol_o)));

endmodule

bind ctl_regfile ctl_regfile_chk #(
    .DAC_CH (DAC_CH),
    .ADC_CH (ADC_CH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .mute_o      (mute_o),
    .invert_o    (invert_o),
    .dac_vol_o   (dac_vol_o),
    .adc_vol_o   (adc_vol_o),
    .freeze_o    (freeze_o),
    .aux_i2s_o   (aux_i2s_o),
    .ratio_sel_o (ratio_sel_o)
);

// File: tb/tb_ctl_regfile.sv
module tb_ctl_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int DAC_CH = 4;
    localparam int ADC_CH = 2;
    localparam int ADDR_W = 5;
    localparam int CH_TOT = DAC_CH + ADC_CH;
    localparam int NSTG   = 2 + CH_TOT;

    logic                clk = 0;
    logic                rst_n = 0;
    logic                wr_en = 0;
    logic [ADDR_W-1:0]   addr = '0;
    logic [7:0]          wr_data = '0;
    logic [7:0]          rd_data;
    logic [CH_TOT-1:0]   mute_o, invert_o;
    logic [8*DAC_CH-1:0] dac_vol_o;
    logic [8*ADC_CH-1:0] adc_vol_o;
    logic                freeze_o, aux_i2s_o;
    logic [2:0]          ratio_sel_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference model state
    int  m_pend[NSTG];
    int  m_live[NSTG];
    bit  m_frz, m_aux;
    int  m_ratio;

    ctl_regfile #(.DAC_CH(DAC_CH), .ADC_CH(ADC_CH), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .mute_o(mute_o), .invert_o(invert_o),
        .dac_vol_o(dac_vol_o), .adc_vol_o(adc_vol_o), .freeze_o(freeze_o),
        .aux_i2s_o(aux_i2s_o), .ratio_sel_o(ratio_sel_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int reg_mask(int k);
        return (k < 2) ? ((1 << CH_TOT) - 1) : 8'hFF;
    endfunction

    function automatic int exp_rd(int a);
        if (a == 0) return m_ratio << 1;
        if (a == 1) return (int'(m_frz) << 7) | (int'(m_aux) << 6);
        if (a >= 2 && a < 2 + NSTG) return m_pend[a-2];
        return 0;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NSTG; k++) begin m_pend[k] = 0; m_live[k] = 0; end
        m_frz = 0; m_aux = 0; m_ratio = 0;
    endtask

    task automatic model_write(int a, int d);
        if (a == 0) m_ratio = (d >> 1) & 7;
        else if (a == 1) begin
            bit nf = d[7];
            m_aux = d[6];
            if (m_frz && !nf)
                for (int k = 0; k < NSTG; k++) m_live[k] = m_pend[k];
            m_frz = nf;
        end else if (a >= 2 && a < 2 + NSTG) begin
            m_pend[a-2] = d & reg_mask(a-2);
            if (!m_frz) m_live[a-2] = m_pend[a-2];
        end
    endtask

    task automatic cmp_outputs(string tag);
        chk(tag, "mute_o", int'(mute_o), m_live[0]);
        chk(tag, "invert_o", int'(invert_o), m_live[1]);
        for (int i = 0; i < DAC_CH; i++)
            chk(tag, $sformatf("dac_vol[%0d]", i), int'(dac_vol_o[i*8 +: 8]), m_live[2+i]);
        for (int j = 0; j < ADC_CH; j++)
            chk(tag, $sformatf("adc_vol[%0d]", j), int'(adc_vol_o[j*8 +: 8]), m_live[2+DAC_CH+j]);
        chk(tag, "freeze_o", int'(freeze_o), int'(m_frz));
        chk(tag, "aux_i2s_o", int'(aux_i2s_o), int'(m_aux));
        chk(tag, "ratio_sel_o", int'(ratio_sel_o), (m_ratio & 4) ? 4 : (m_ratio & 3));
    endtask

    task automatic step(bit we, int a, int d, string tag);
        @(negedge clk);
        wr_en = we; addr = ADDR_W'(a); wr_data = 8'(d);
        #1;
        chk(tag, $sformatf("rd_data@0x%0h", a), int'(rd_data), exp_rd(a));
        @(posedge clk);
        #1;
        if (we) model_write(a, d);
        cmp_outputs(tag);
    endtask

    task automatic wr(int a, int d, string tag); step(1, a, d, tag); endtask
    task automatic rd(int a, string tag);        step(0, a, 0, tag); endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        cmp_outputs("R1 in reset");
        @(negedge clk);
        rst_n = 1;
        // R1: everything reads zero after reset
        for (int a = 0; a < 12; a++) rd(a, "R1");

        // R3: every ratio code, read back and decoded
        for (int c = 0; c < 8; c++) begin
            wr(0, (c << 1) | 8'hF1, "R3");
            rd(0, "R3 R4");
        end

        // R4: reserved bits
        wr(1, 8'h3F, "R4");
        rd(1, "R4");
        wr(2, 8'hFF, "R4");
        rd(2, "R4");
        wr(3, 8'hC5, "R4");
        rd(3, "R4");

        // R2: format bit
        wr(1, 8'h40, "R2");
        rd(1, "R2");

        // R5: direct writes with freeze clear
        wr(2, 8'h15, "R5");
        for (int k = 0; k < CH_TOT; k++) wr(4 + k, 8'h10 + 8'h21 * k, "R5");

        // R10: enter freeze, then rewrite misc with freeze held
        wr(1, 8'hC0, "R10");
        wr(1, 8'h80, "R10");

        // R6/R7: stage new values, live holds, reads show pending
        wr(2, 8'h2A, "R6");
        wr(3, 8'h33, "R6");
        for (int k = 0; k < CH_TOT; k++) wr(4 + k, 8'hF0 - 8'h0B * k, "R6");
        for (int k = 0; k < NSTG; k++) rd(2 + k, "R7");
        wr(4, 8'h77, "R7");
        rd(4, "R7");

        // R8: release freeze, read mute on the next cycle
        wr(1, 8'h40, "R8");
        rd(2, "R8");
        for (int k = 0; k < NSTG; k++) rd(2 + k, "R8");

        // R9: unmapped writes and reads
        for (int a = 10; a < 32; a++) wr(a, 8'hA5, "R9");
        for (int a = 10; a < 32; a++) rd(a, "R9");
        for (int a = 0; a < 10; a++) rd(a, "R9");

        // second freeze cycle with an unmapped write in the middle
        wr(1, 8'h80, "R6");
        wr(5, 8'h01, "R6");
        wr(20, 8'hFF, "R9");
        wr(2, 8'h01, "R6");
        wr(1, 8'h00, "R8");
        rd(2, "R8");

        @(negedge clk);
        wr_en = 0;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule